// File: doc/BRIEF.md
# High-speed transmitter slew-rate calibration sequencer

This block runs the slew-rate calibration of one port's high-speed transmitter. A start pulse names the port. The sequencer then turns on three things in order: the port's ring oscillator, the free-running measurement clock and the frequency meter. Before it arms the meter it gives the meter a 1024-cycle window and the port's channel. It waits until the meter reports a valid count or until a timeout expires. In both cases it then reads the count.

After the read it turns off the meter and then the free-running clock. It converts the count into a 3-bit slew code with a multicycle restoring divider, writes the code, and turns off the oscillator while it pulses done. The oscillator settling delay and the timeout are counted in ticks from a parameterized prescaler. The meter and the analog oscillator are outside the block.

Top module: `hs_slew_cal`

## Requirements
- R1: After reset, all three enables, `done_o`, `code_o`, `chan_o` and `win_len_o` are zero.
- R2: The enables rise in a fixed order. `osc_en_o` rises first. `frun_en_o` rises at least DLY_TICKS×PRE cycles later. `meter_en_o` rises strictly after `frun_en_o`, and only after the window and channel outputs have been set.
- R3: While `meter_en_o` is high, `win_len_o` equals WIN (1024) and `chan_o` equals the port index that was sampled with the accepted start pulse.
- R4: While the meter is enabled, the block samples `meter_count_i` in the first cycle in which `meter_valid_i` is high. Count values presented before that cycle are not used.
- R5: If `meter_valid_i` never rises, the block reads `meter_count_i` after TMO_TICKS×PRE cycles of meter enable and continues the sequence.
- R6: For a nonzero count C, `code_o` becomes the low 3 bits of floor((floor(745472 / C) + 500) / 1000). The constant 745472 is 1024 × 26 × 28, so the code is the ratio to C divided by 1000 and rounded to the nearest integer, with halves rounded up.
- R7: A count of zero gives the code 4.
- R8: The enables fall in a fixed order. `meter_en_o` falls first, then `frun_en_o`, then `osc_en_o`. The new code is already on `code_o` in the last cycle before `osc_en_o` falls.
- R9: `done_o` is high for exactly one cycle, in the first cycle in which `osc_en_o` is low again. `code_o` changes only while the oscillator is enabled.
- R10: A start pulse that arrives while a sequence is running is ignored. It does not change the channel and does not produce another done pulse or another oscillator enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| port_i | input | PORT_W | Port index to calibrate |
| meter_valid_i | input | 1 | Meter reports a finished measurement |
| meter_count_i | input | CNT_W | Measured oscillator count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frun_en_o | output | 1 | Free-running measurement clock enable |
| meter_en_o | output | 1 | Frequency meter enable |
| win_len_o | output | $clog2(WIN+1) | Measurement window length in cycles |
| chan_o | output | PORT_W | Meter channel select |
| code_o | output | 3 | Slew-rate code |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The bench checks the conversion in several places:
- Counts 497 and 496 sit on either side of a rounding boundary. A design that truncates instead of rounding returns 1 for both.
- Count 93 yields 8, which must wrap to 0. A design that saturates would return 7.
- A zero count must give the fallback code 4. A design that divides by zero anyway gives a code that depends on the divider.

The meter model shows zero as the count until valid rises. A design that samples too early therefore returns 4 instead of the true code. A run with no valid at all checks that the sequence still finishes with the count that was on the input, rather than hanging. A start pulse issued in the middle of a run must leave the channel unchanged and must not restart the oscillator.

// File: rtl/hs_slew_cal.sv
module hs_slew_cal #(
  parameter int PORT_W    = 2,
  parameter int CNT_W     = 16,
  parameter int WIN       = 1024,
  parameter int REF_MHZ   = 26,
  parameter int SR_COEF   = 28,
  parameter int SR_DIV    = 1000,
  parameter int DEF_CODE  = 4,
  parameter int PRE       = 100,
  parameter int DLY_TICKS = 1,
  parameter int TMO_TICKS = 200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [PORT_W-1:0]          port_i,
  input  logic                       meter_valid_i,
  input  logic [CNT_W-1:0]           meter_count_i,
  output logic                       osc_en_o,
  output logic                       frun_en_o,
  output logic                       meter_en_o,
  output logic [$clog2(WIN+1)-1:0]   win_len_o,
  output logic [PORT_W-1:0]          chan_o,
  output logic [2:0]                 code_o,
  output logic                       done_o
);
  localparam int NUM   = WIN * REF_MHZ * SR_COEF;
  localparam int HALF  = SR_DIV / 2;
  localparam int NW    = $clog2(NUM + SR_DIV + 1);
  localparam int BW    = $clog2(NW + 1);
  localparam int WIN_W = $clog2(WIN + 1);
  localparam int PW    = $clog2(PRE + 1);
  localparam int TMAX  = (DLY_TICKS > TMO_TICKS) ? DLY_TICKS : TMO_TICKS;
  localparam int TW    = $clog2(TMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DLY, S_CFG, S_ARM, S_POLL, S_FOFF,
    S_DIV1, S_MID, S_DIV2, S_WR, S_OFF
  } st_t;

  st_t               st;
  logic [PORT_W-1:0] port_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              zero_q;
  logic [PW-1:0]     pcnt;
  logic [TW-1:0]     tcnt;
  logic [NW-1:0]     rem, quo, dvs;
  logic [BW-1:0]     bcnt;

  // prescaled tick timing, shared by the settle delay and the meter timeout
  logic          tick, wait_end;
  logic [TW-1:0] limit;
  assign tick     = (pcnt == PW'(PRE - 1));
  assign limit    = (st == S_DLY) ? TW'(DLY_TICKS - 1) : TW'(TMO_TICKS - 1);
  assign wait_end = tick && (tcnt == limit);

  // one restoring division step
  logic [NW:0]   trial;
  logic          take;
  logic [NW-1:0] diff;
  logic          last_bit;
  assign trial    = {rem, quo[NW-1]};
  assign take     = (trial >= {1'b0, dvs});
  assign diff     = trial[NW-1:0] - dvs;
  assign last_bit = (bcnt == BW'(NW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      port_q     <= '0;
      cnt_q      <= '0;
      zero_q     <= 1'b0;
      pcnt       <= '0;
      tcnt       <= '0;
      rem        <= '0;
      quo        <= '0;
      dvs        <= '0;
      bcnt       <= '0;
      osc_en_o   <= 1'b0;
      frun_en_o  <= 1'b0;
      meter_en_o <= 1'b0;
      win_len_o  <= '0;
      chan_o     <= '0;
      code_o     <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          osc_en_o <= 1'b1;
          port_q   <= port_i;
          pcnt     <= '0;
          tcnt     <= '0;
          st       <= S_DLY;
        end
        S_DLY: begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) tcnt <= tcnt + 1'b1;
          if (wait_end) begin
            frun_en_o <= 1'b1;
            st        <= S_CFG;
          end
        end
        S_CFG: begin
          chan_o    <= port_q;
          win_len_o <= WIN_W'(WIN);
          st        <= S_ARM;
        end
        S_ARM: begin
          meter_en_o <= 1'b1;
          pcnt       <= '0;
          tcnt       <= '0;
          st         <= S_POLL;
        end
        S_POLL: begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) tcnt <= tcnt + 1'b1;
          if (meter_valid_i || wait_end) begin
            cnt_q      <= meter_count_i;
            meter_en_o <= 1'b0;
            st         <= S_FOFF;
          end
        end
        S_FOFF: begin
          frun_en_o <= 1'b0;
          zero_q    <= (cnt_q == '0);
          rem       <= '0;
          quo       <= NW'(NUM);
          dvs       <= NW'(cnt_q);
          bcnt      <= '0;
          st        <= (cnt_q == '0) ? S_WR : S_DIV1;
        end
        S_DIV1, S_DIV2: begin
          rem  <= take ? diff : trial[NW-1:0];
          quo  <= {quo[NW-2:0], take};
          bcnt <= bcnt + 1'b1;
          if (last_bit) st <= (st == S_DIV1) ? S_MID : S_WR;
        end
        S_MID: begin
          quo  <= quo + NW'(HALF);
          rem  <= '0;
          dvs  <= NW'(SR_DIV);
          bcnt <= '0;
          st   <= S_DIV2;
        end
        S_WR: begin
          code_o <= zero_q ? 3'(DEF_CODE) : quo[2:0];
          st     <= S_OFF;
        end
        S_OFF: begin
          osc_en_o <= 1'b0;
          done_o   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_frun_needs_osc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frun_en_o |-> osc_en_o);
  p_meter_needs_frun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    meter_en_o |-> frun_en_o);
  p_window_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    meter_en_o |-> (win_len_o == WIN_W'(WIN)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!osc_en_o && !frun_en_o && !meter_en_o));
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en_o |=> $stable(code_o));
endmodule

// File: tb/tb_hs_slew_cal.sv
module tb_hs_slew_cal;
  localparam int PRE = 5, DLY = 2, TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mv = 1'b0;
  logic [1:0]  port = '0;
  logic [15:0] mc = '0;
  logic osc, frun, meter, done;
  logic [10:0] win;
  logic [1:0]  chan;
  logic [2:0]  code;

  hs_slew_cal #(.PRE(PRE), .DLY_TICKS(DLY), .TMO_TICKS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .port_i(port),
    .meter_valid_i(mv), .meter_count_i(mc), .osc_en_o(osc),
    .frun_en_o(frun), .meter_en_o(meter), .win_len_o(win),
    .chan_o(chan), .code_o(code), .done_o(done));

  always #5 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0, n_done = 0;
  int t_osc_on, t_osc_off, t_frun_on, t_frun_off, t_m_on, t_m_off, t_done;
  logic [1:0]  chan_at;
  logic [10:0] win_at;
  logic [2:0]  code_before_off, p_code = '0;
  logic p_osc = 0, p_frun = 0, p_meter = 0;

  // meter model settings
  bit use_valid = 1;
  int lat = 3, lat_cnt = 0;
  logic [15:0] cnt_val = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (osc && !p_osc) t_osc_on = cyc;
    if (!osc && p_osc) begin t_osc_off = cyc; code_before_off = p_code; end
    if (frun && !p_frun) t_frun_on = cyc;
    if (!frun && p_frun) t_frun_off = cyc;
    if (meter && !p_meter) begin t_m_on = cyc; chan_at = chan; win_at = win; end
    if (!meter && p_meter) t_m_off = cyc;
    if (done) begin n_done++; t_done = cyc; end
    p_osc = osc; p_frun = frun; p_meter = meter; p_code = code;
    if (!meter) begin lat_cnt = 0; mv = 1'b0; end
    else begin lat_cnt++; mv = use_valid && (lat_cnt >= lat); end
    mc = (use_valid && !mv) ? 16'd0 : cnt_val;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int c);
    if (c == 0) return 4;
    return (((745472 / c) + 500) / 1000) & 7;
  endfunction

  task automatic pulse_start(input logic [1:0] p);
    @(negedge clk); port = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
  endtask

  task automatic run_cal(input logic [1:0] p, input int c, input bit v, input string what);
    int d0, e;
    e = exp_code(c);
    use_valid = v; cnt_val = 16'(c); d0 = n_done;
    pulse_start(p);
    wait_done();
    chk(n_done - d0 == 1, {"R9 one done ", what}, n_done - d0, 1);
    chk(done == 1'b0, {"R9 done low after pulse ", what}, done, 0);
    chk(t_done == t_osc_off, {"R9 done with osc off ", what}, t_done, t_osc_off);
    chk(t_frun_on - t_osc_on >= DLY * PRE, {"R2 settle delay ", what},
        t_frun_on - t_osc_on, DLY * PRE);
    chk(t_m_on > t_frun_on + 1, {"R2 meter after setup ", what}, t_m_on, t_frun_on + 2);
    chk(win_at == 11'd1024, {"R3 window ", what}, win_at, 1024);
    chk(chan_at == p, {"R3 channel ", what}, chan_at, p);
    chk(t_m_off < t_frun_off && t_frun_off < t_osc_off, {"R8 disable order ", what},
        t_frun_off, t_m_off + 1);
    chk(code_before_off == 3'(e), {"R8 code before osc off ", what}, code_before_off, e);
    if (v) chk(t_m_off - t_m_on < TMO * PRE, {"R4 valid ends wait ", what},
               t_m_off - t_m_on, lat);
    else   chk(t_m_off - t_m_on >= TMO * PRE, {"R5 timeout length ", what},
               t_m_off - t_m_on, TMO * PRE);
    if (c == 0) chk(code == 3'd4, {"R7 zero count ", what}, code, 4);
    else        chk(code == 3'(e), {"R6 code ", what}, code, e);
  endtask

  task automatic test_reset();
    chk(!osc && !frun && !meter && !done, "R1 enables and done", {osc, frun, meter, done}, 0);
    chk(code == 3'd0 && chan == 2'd0 && win == 11'd0, "R1 code/chan/win", code, 0);
  endtask

  task automatic test_busy_start();
    int d0, on0;
    use_valid = 1; cnt_val = 16'd300; d0 = n_done;
    pulse_start(2'd1);
    for (int i = 0; i < 200 && !meter; i++) @(negedge clk);
    on0 = t_osc_on;
    pulse_start(2'd3);
    chk(chan == 2'd1, "R10 channel kept", chan, 1);
    wait_done();
    repeat (40) @(negedge clk);
    chk(n_done - d0 == 1, "R10 single done", n_done - d0, 1);
    chk(t_osc_on == on0 && !osc, "R10 no restart", t_osc_on, on0);
    chk(code == 3'(exp_code(300)), "R10 R6 code", code, exp_code(300));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cal(2'd0, 745, 1, "c745");
    run_cal(2'd1, 497, 1, "c497 round down");
    run_cal(2'd2, 496, 1, "c496 round up");
    run_cal(2'd3, 100, 1, "c100");
    run_cal(2'd0, 93, 1, "c93 wrap");
    run_cal(2'd1, 1, 1, "c1");
    run_cal(2'd2, 0, 1, "c0");
    run_cal(2'd3, 149, 0, "timeout c149");
    run_cal(2'd0, 0, 0, "timeout c0");
    run_cal(2'd1, 65535, 1, "cmax");
    test_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule